// File: doc/BRIEF.md
# Dual-Order Wraparound Burst Address Sequencer

This block generates the word addresses of a four-word burst. When either of two address strobes is active at a rising clock edge, it captures the full incoming address. The two lowest bits become the burst start offset and a step count restarts at zero. After that, every edge with the advance input high moves the burst one word forward. The offset wraps inside the aligned four-word group. The bits above the offset come from the captured address and pass through unchanged.

A mode input chooses the word ordering. In interleaved order each word offset is the start offset XOR the step count. In linear order it is the start offset plus the step count, modulo four. The block presents the current full word address and the position inside the burst. Choosing between the strobes and accessing the storage array are left to the surrounding logic.

Top module: `burst_seq_counter`

## Requirements
- R1: A clock edge with `rst_n` low sets `word_addr_o` to all zeros and `burst_pos_o` to 0.
- R2: A clock edge with `host_strobe_i` or `ctl_strobe_i` high (alone or together) captures `addr_i`. After that edge `word_addr_o` equals the captured address and `burst_pos_o` is 0, in either order mode.
- R3: A clock edge with both strobes low and `advance_i` high adds one to `burst_pos_o`, modulo 4. `word_addr_o` then moves to the next word of the selected order.
- R4: A clock edge with both strobes and `advance_i` low leaves `burst_pos_o` and `word_addr_o` unchanged.
- R5: With `order_sel_i` = 1 (interleaved), the low two bits of `word_addr_o` equal start XOR position. The start offsets 00, 01, 10 and 11 therefore step through 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R6: With `order_sel_i` = 0 (linear), the low two bits of `word_addr_o` equal (start + position) mod 4. The start offsets 00, 01, 10 and 11 therefore step through 00-01-10-11, 01-10-11-00, 10-11-00-01 and 11-00-01-10.
- R7: The fourth advance after a load returns `burst_pos_o` to 0 and `word_addr_o` to the start address.
- R8: A strobe takes priority over `advance_i` at the same edge. It reloads the burst even partway through one.
- R9: Bits `word_addr_o[15:2]` change only at an edge where a strobe is high. Changes on `addr_i` at any other edge have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_strobe_i | input | 1 | First address strobe, active high |
| ctl_strobe_i | input | 1 | Second address strobe, active high |
| addr_i | input | 16 | Word address sampled when a strobe is high |
| advance_i | input | 1 | Step to the next word of the burst, active high |
| order_sel_i | input | 1 | Ordering: 1 interleaved, 0 linear; held static |
| word_addr_o | output | 16 | Current word address |
| burst_pos_o | output | 2 | Position within the burst (step count) |

## Verification
The block has one register stage, so every load, advance, hold or reset shows up on the outputs straight after the edge that samples it. The order selection acts combinationally on those registered values. The driver applies each stimulus at the falling edge and pushes the outputs that stimulus should give into a scoreboard queue. The monitor pops one entry 1 ns after each rising edge, which keeps every comparison exactly one edge after its stimulus. Every cycle, including reset and hold cycles, is compared against the queue.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_seq_pkg;

    // Word ordering inside a burst group; encoding matches the order_sel_i pin
    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_addr_capture.sv
// Captures the address on a load strobe and splits it into the upper
// part (passed through) and the in-group start offset.
// Assumes: ADDR_W > WORD_BITS; load_i is already the OR of all strobes.
module burst_addr_capture #(
    parameter int ADDR_W    = 16,
    parameter int WORD_BITS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic [ADDR_W-WORD_BITS-1:0] upper_o,
    output logic [WORD_BITS-1:0]        base_o
);

    // Hold captured address; cleared by reset, reloaded on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_o <= '0;
            base_o  <= '0;
        end else if (load_i) begin
            upper_o <= addr_i[ADDR_W-1:WORD_BITS];
            base_o  <= addr_i[WORD_BITS-1:0];
        end
    end

endmodule

// File: rtl/burst_step_counter.sv
// Running step count of the burst: restarts at zero on a load, increments
// on advance, and wraps naturally at 2**WORD_BITS.
// Assumes: load has priority over advance.
module burst_step_counter #(
    parameter int WORD_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 adv_i,
    output logic [WORD_BITS-1:0] step_o
);

    localparam logic [WORD_BITS-1:0] ONE = WORD_BITS'(1);

    // Restart, advance or hold the step count
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_o <= '0;
        else if (load_i)
            step_o <= '0;
        else if (adv_i)
            step_o <= step_o + ONE;
    end

endmodule

// File: rtl/burst_order_gen.sv
// Combines start offset and step count into the in-group word offset,
// either as a bitwise XOR (interleaved) or a modular sum (linear).
// Assumes: purely combinational; order_i is static during a burst.
module burst_order_gen
    import burst_seq_pkg::*;
#(
    parameter int WORD_BITS = 2
) (
    input  logic [WORD_BITS-1:0] base_i,
    input  logic [WORD_BITS-1:0] step_i,
    input  burst_order_e         order_i,
    output logic [WORD_BITS-1:0] ofs_o
);

    logic [WORD_BITS-1:0] xor_ofs;
    logic [WORD_BITS-1:0] sum_ofs;

    // Interleaved offset: one XOR per offset bit
    for (genvar b = 0; b < WORD_BITS; b++) begin : g_xor_bit
        assign xor_ofs[b] = base_i[b] ^ step_i[b];
    end

    // Linear offset: sum truncated to the group width
    always_comb sum_ofs = base_i + step_i;

    // Pick the offset for the selected ordering
    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVED: ofs_o = xor_ofs;
            default:         ofs_o = sum_ofs;
        endcase
    end

endmodule

// File: rtl/burst_seq_counter.sv
// Top of the burst address sequencer. Either strobe loads a new burst
// start; advance steps through a 2**WORD_BITS word group in linear or
// interleaved order; upper address bits pass through from the capture.
// Assumes: synchronous active-low reset; order_sel_i static while bursting.
module burst_seq_counter
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORD_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_strobe_i,
    input  logic                 ctl_strobe_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 advance_i,
    input  logic                 order_sel_i,
    output logic [ADDR_W-1:0]    word_addr_o,
    output logic [WORD_BITS-1:0] burst_pos_o
);

    localparam int UPPER_W = ADDR_W - WORD_BITS;

    logic                 load;
    logic [UPPER_W-1:0]   upper;
    logic [WORD_BITS-1:0] base;
    logic [WORD_BITS-1:0] step;
    logic [WORD_BITS-1:0] ofs;
    burst_order_e         order;

    // Either strobe starts a burst
    always_comb load = host_strobe_i | ctl_strobe_i;

    // Map the mode pin onto the ordering type
    always_comb order = burst_order_e'(order_sel_i);

    burst_addr_capture #(
        .ADDR_W   (ADDR_W),
        .WORD_BITS(WORD_BITS)
    ) capture_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .addr_i (addr_i),
        .upper_o(upper),
        .base_o (base)
    );

    burst_step_counter #(
        .WORD_BITS(WORD_BITS)
    ) step_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .adv_i (advance_i),
        .step_o(step)
    );

    burst_order_gen #(
        .WORD_BITS(WORD_BITS)
    ) order_i (
        .base_i (base),
        .step_i (step),
        .order_i(order),
        .ofs_o  (ofs)
    );

    // Assemble the outputs
    always_comb begin
        word_addr_o = {upper, ofs};
        burst_pos_o = step;
    end

endmodule

// File: rtl/burst_seq_counter_chk.sv
// Property checker for burst_seq_counter, attached by bind below.
// Assumes: observes top-level ports only.
module burst_seq_counter_chk #(
    parameter int ADDR_W    = 16,
    parameter int WORD_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_strobe_i,
    input logic                 ctl_strobe_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 advance_i,
    input logic                 order_sel_i,
    input logic [ADDR_W-1:0]    word_addr_o,
    input logic [WORD_BITS-1:0] burst_pos_o
);

    logic                 strobe;
    logic [WORD_BITS-1:0] low;
    logic [WORD_BITS-1:0] xor_key;
    logic [WORD_BITS-1:0] lin_key;

    always_comb begin
        strobe  = host_strobe_i | ctl_strobe_i;
        low     = word_addr_o[WORD_BITS-1:0];
        xor_key = low ^ burst_pos_o;
        lin_key = low - burst_pos_o;
    end

    // R1: the reset edge clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (word_addr_o == '0 && burst_pos_o == '0));

    // R2, R8: a strobe loads the address whatever advance does
    p_strobe_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (word_addr_o == $past(addr_i) && burst_pos_o == '0));

    // R3: advance steps the position by one
    p_advance_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && advance_i) |=> burst_pos_o == WORD_BITS'($past(burst_pos_o) + 1'b1));

    // R4: no strobe and no advance holds the outputs
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !advance_i) |=> ($stable(burst_pos_o) &&
                                     (!$stable(order_sel_i) || $stable(word_addr_o))));

    // R5: in interleaved order, offset XOR position is constant during a burst
    p_interleave_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && order_sel_i) |=> (!order_sel_i || xor_key == $past(xor_key)));

    // R6: in linear order, offset minus position is constant during a burst
    p_linear_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !order_sel_i) |=> (order_sel_i || lin_key == $past(lin_key)));

    // R9: the upper address bits change only on a strobe
    p_upper_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(word_addr_o[ADDR_W-1:WORD_BITS]));

endmodule

bind burst_seq_counter burst_seq_counter_chk #(
    .ADDR_W   (ADDR_W),
    .WORD_BITS(WORD_BITS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_strobe_i(host_strobe_i),
    .ctl_strobe_i (ctl_strobe_i),
    .addr_i       (addr_i),
    .advance_i    (advance_i),
    .order_sel_i  (order_sel_i),
    .word_addr_o  (word_addr_o),
    .burst_pos_o  (burst_pos_o)
);

// File: tb/burst_seq_counter_tb_top.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
`timescale 1ns/1ps
module burst_seq_counter_tb_top;

    localparam int AW = 16;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    pos;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_strobe_i = 1'b0;
    logic          ctl_strobe_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          advance_i = 1'b0;
    logic          order_sel_i = 1'b0;
    logic [AW-1:0] word_addr_o;
    logic [1:0]    burst_pos_o;

    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // reference state, built from the requirements
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_base = '0;
    logic [1:0]    m_step = '0;

    always #2 clk = ~clk;

    burst_seq_counter #(.ADDR_W(AW), .WORD_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_strobe_i(host_strobe_i), .ctl_strobe_i(ctl_strobe_i),
        .addr_i(addr_i), .advance_i(advance_i), .order_sel_i(order_sel_i),
        .word_addr_o(word_addr_o), .burst_pos_o(burst_pos_o)
    );

    task automatic drive(input logic rst, input logic hs, input logic cs,
                         input logic [AW-1:0] a, input logic adv, input logic md);
        exp_t e;
        logic [1:0] lo;
        @(negedge clk);
        rst_n = rst; host_strobe_i = hs; ctl_strobe_i = cs;
        addr_i = a; advance_i = adv; order_sel_i = md;
        if (!rst) begin
            m_up = '0; m_base = '0; m_step = '0; e.tag = "R1";
        end else if (hs || cs) begin
            m_up = a[AW-1:2]; m_base = a[1:0]; m_step = '0;
            e.tag = adv ? "R8" : "R2";
        end else if (adv) begin
            m_step = m_step + 2'd1;
            if (m_step == 2'd0) e.tag = "R7";
            else e.tag = md ? "R3/R5" : "R3/R6";
        end else begin
            e.tag = "R4/R9";
        end
        lo = md ? (m_base ^ m_step) : (m_base + m_step);
        e.addr = {m_up, lo};
        e.pos  = m_step;
        sb_q.push_back(e);
    endtask

    // monitor: one expected entry per rising edge, sampled 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                tests++;
                if (word_addr_o !== e.addr || burst_pos_o !== e.pos) begin
                    fails++;
                    $display("FAIL %s: addr=%h pos=%0d expected addr=%h pos=%0d",
                             e.tag, word_addr_o, burst_pos_o, e.addr, e.pos);
                end
            end
        end
    end

    // stimulus
    initial begin
        logic [AW-1:0] a;
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1);
        for (int md = 0; md < 2; md++) begin
            for (int b = 0; b < 4; b++) begin
                a = {14'(16'h1A5 * (b + 3) + md * 16'h2C1), 2'(b)};
                drive(1'b1, (b % 2) == 0, (b % 2) == 1, a, 1'b0, md[0]);
                for (int k = 0; k < 5; k++) drive(1'b1, 1'b0, 1'b0, ~a, 1'b1, md[0]);
                drive(1'b1, 1'b0, 1'b0, 16'h0F0F, 1'b0, md[0]);
                drive(1'b1, 1'b0, 1'b0, 16'hF0F2, 1'b0, md[0]);
            end
            // mid-burst reload with advance high, both strobes together (R8)
            drive(1'b1, 1'b1, 1'b0, 16'h4441, 1'b0, md[0]);
            drive(1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, md[0]);
            drive(1'b1, 1'b1, 1'b1, 16'hBEE3, 1'b1, md[0]);
            drive(1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, md[0]);
            drive(1'b1, 1'b0, 1'b1, 16'h7776, 1'b1, md[0]);
        end
        // reset in mid-burst (R1)
        drive(1'b1, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 16'h1234, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #2;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d scoreboard entries left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R1: watchdog expired, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule